// File: doc/BRIEF.md
# Flash Polling-Status Read Generator

This block decides what a parallel NOR-style flash model drives onto its read data bus while an embedded program or erase operation is running. When the host reads during such an operation, the most significant data bit carries a polling status. For a program, that bit is the inverse of the bit being written. For an erase, it is a fixed value. Once the operation ends, the bus returns to normal array data.

The operation context is captured on the clock edge that samples the final command strobe. That context is the target address, the status-relevant bit of the datum, the selected erase sectors, and which of them are unprotected. Status is then shown only to reads that hit that context. If a program targets a protected sector, or no selected erase sector is unprotected, the block shows busy status for a fixed number of cycles and then falls back to array read. It does this on its own, ignoring the external busy flag.

The sector of an address is its top `SECT_BITS` bits. In a status word, bits below the MSB are driven as zero.

Top module: `poll_status_gen`

## Requirements
- R1: When no operation is active, including right after reset, `rd_data` equals `array_data`.
- R2: During a busy program, a read at the captured address returns bit 7 equal to the inverse of the captured datum bit, with bits 6..0 zero.
- R3: In the single cycle after the busy flag is seen low, bit 7 already shows its final value while bits 6..0 are still zero. For a program this final value is the datum bit (at the captured address); for an erase it is 1 (inside an erased sector). In the following cycle the block is back to array read.
- R4: During a busy erase, a read inside a selected unprotected sector returns bit 7 = 0, or 1 while `erase_susp` is high, with bits 6..0 zero.
- R5: Reads at any other address return `array_data`. For a program, this is any address other than the captured one. For an erase, it is any sector not both selected and unprotected; during the protected-erase window it is any sector that was not selected.
- R6: A program whose target sector is protected shows busy status (inverted datum bit) for exactly PROG_GUARD cycles regardless of `core_busy`, then returns to array read.
- R7: An erase with no selected unprotected sector shows bit 7 = 0 in selected sectors for exactly ERASE_GUARD cycles, then returns to array read.
- R8: `op_start` is ignored while an operation or window is active. The address, datum bit, sector selection and protection inputs have no effect after the start edge.
- R9: Status appears in the cycle right after the clock edge that samples `op_start` high (`op_is_erase` = 1 selects erase, 0 program).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Final command strobe, one cycle |
| op_is_erase | input | 1 | 1 = erase, 0 = program; sampled with op_start |
| core_busy | input | 1 | Embedded algorithm still running |
| erase_susp | input | 1 | Erase is suspended |
| rd_addr | input | ADDR_W | Host read address |
| array_data | input | DATA_W | Array contents at rd_addr |
| prog_addr | input | ADDR_W | Last word address loaded for programming |
| prog_msb | input | 1 | Bit 7 of the datum being programmed |
| erase_sel | input | 2**SECT_BITS | Sectors chosen for erase |
| sect_prot | input | 2**SECT_BITS | Sector protection flags |
| rd_data | output | DATA_W | Data driven to the host |

## Verification
Directed sequences cover several cases: an unprotected program with reads both at the target and elsewhere, a partly protected erase with suspension, an all-protected erase, an empty erase selection, and a protected program with the busy flag held high. Together these separate the address qualification, the sector mask, and the timed window from the busy-driven path. Seeded random cycles then mix late changes to the operation inputs, start pulses during active operations, random suspension and random protection masks. These catch any use of live inputs where captured context is required. Tail cycles are compared one by one, which distinguishes an early final bit 7 from an immediate return to array data.

// File: rtl/poll_status_pkg.sv
package poll_status_pkg;
  typedef enum logic [2:0] {
    PS_IDLE  = 3'd0,
    PS_PROG  = 3'd1,
    PS_ERASE = 3'd2,
    PS_TAIL  = 3'd3,
    PS_GUARD = 3'd4
  } pstate_e;

  typedef enum logic {
    OPK_PROG  = 1'b0,
    OPK_ERASE = 1'b1
  } opkind_e;
endpackage

// File: rtl/poll_ctx.sv
module poll_ctx #(
  parameter int ADDR_W = 12,
  parameter int NSECT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              prog_msb,
  input  logic [NSECT-1:0]  erase_sel,
  input  logic [NSECT-1:0]  sect_prot,
  output logic [ADDR_W-1:0] addr_q,
  output logic              dat7_q,
  output logic [NSECT-1:0]  sel_q,
  output logic [NSECT-1:0]  eff_q
);
  logic [ADDR_W-1:0] addr_d;
  logic              dat7_d;
  logic [NSECT-1:0]  sel_d, eff_d;

  always_comb begin
    addr_d = addr_q;
    dat7_d = dat7_q;
    sel_d  = sel_q;
    eff_d  = eff_q;
    if (take) begin
      addr_d = prog_addr;
      dat7_d = prog_msb;
      sel_d  = erase_sel;
      eff_d  = erase_sel & ~sect_prot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dat7_q <= 1'b0;
      sel_q  <= '0;
      eff_q  <= '0;
    end else begin
      addr_q <= addr_d;
      dat7_q <= dat7_d;
      sel_q  <= sel_d;
      eff_q  <= eff_d;
    end
  end
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
  import poll_status_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int PROG_GUARD  = 4,
  parameter int ERASE_GUARD = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    op_start,
  input  logic    op_is_erase,
  input  logic    core_busy,
  input  logic    prog_hit_prot,
  input  logic    erase_none_live,
  output pstate_e st,
  output opkind_e kind,
  output logic    take
);
  localparam logic [CNT_W-1:0] P_LOAD = CNT_W'(PROG_GUARD - 1);
  localparam logic [CNT_W-1:0] E_LOAD = CNT_W'(ERASE_GUARD - 1);

  pstate_e          st_d;
  opkind_e          kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign take = op_start && (st == PS_IDLE);

  always_comb begin
    st_d   = st;
    kind_d = kind;
    cnt_d  = cnt_q;
    case (st)
      PS_IDLE: begin
        if (op_start) begin
          kind_d = op_is_erase ? OPK_ERASE : OPK_PROG;
          if (op_is_erase) begin
            if (erase_none_live) begin
              st_d  = PS_GUARD;
              cnt_d = E_LOAD;
            end else begin
              st_d = PS_ERASE;
            end
          end else if (prog_hit_prot) begin
            st_d  = PS_GUARD;
            cnt_d = P_LOAD;
          end else begin
            st_d = PS_PROG;
          end
        end
      end
      PS_PROG, PS_ERASE: if (!core_busy) st_d = PS_TAIL;
      PS_TAIL:           st_d = PS_IDLE;
      PS_GUARD: begin
        if (cnt_q == '0) st_d = PS_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default:           st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PS_IDLE;
      kind  <= OPK_PROG;
      cnt_q <= '0;
    end else begin
      st    <= st_d;
      kind  <= kind_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/poll_out.sv
module poll_out
  import poll_status_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 12,
  parameter int SECT_BITS = 3,
  parameter int NSECT     = 8
) (
  input  pstate_e           st,
  input  opkind_e           kind,
  input  logic              erase_susp,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_data,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              dat7_q,
  input  logic [NSECT-1:0]  sel_q,
  input  logic [NSECT-1:0]  eff_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [SECT_BITS-1:0] rd_sect;
  logic addr_hit, in_eff, in_sel, show, sbit;

  assign rd_sect  = rd_addr[ADDR_W-1 -: SECT_BITS];
  assign addr_hit = (rd_addr == addr_q);
  assign in_eff   = eff_q[rd_sect];
  assign in_sel   = sel_q[rd_sect];

  always_comb begin
    show = 1'b0;
    sbit = 1'b0;
    case (st)
      PS_PROG:  begin show = addr_hit; sbit = ~dat7_q;     end
      PS_ERASE: begin show = in_eff;   sbit = erase_susp;  end
      PS_TAIL: begin
        if (kind == OPK_ERASE) begin show = in_eff;   sbit = 1'b1;   end
        else                   begin show = addr_hit; sbit = dat7_q; end
      end
      PS_GUARD: begin
        if (kind == OPK_ERASE) begin show = in_sel;   sbit = 1'b0;    end
        else                   begin show = addr_hit; sbit = ~dat7_q; end
      end
      default: show = 1'b0;
    endcase
  end

  assign rd_data = show ? {sbit, {(DATA_W-1){1'b0}}} : array_data;
endmodule

// File: rtl/poll_status_gen.sv
module poll_status_gen
  import poll_status_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 12,
  parameter int SECT_BITS   = 3,
  parameter int PROG_GUARD  = 4,
  parameter int ERASE_GUARD = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_start,
  input  logic                      op_is_erase,
  input  logic                      core_busy,
  input  logic                      erase_susp,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [DATA_W-1:0]         array_data,
  input  logic [ADDR_W-1:0]         prog_addr,
  input  logic                      prog_msb,
  input  logic [(1<<SECT_BITS)-1:0] erase_sel,
  input  logic [(1<<SECT_BITS)-1:0] sect_prot,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int NSECT   = 1 << SECT_BITS;
  localparam int MAX_G   = (PROG_GUARD > ERASE_GUARD) ? PROG_GUARD : ERASE_GUARD;
  localparam int CNT_W   = (MAX_G < 2) ? 1 : $clog2(MAX_G);

  pstate_e           st;
  opkind_e           kind;
  logic              take, prog_hit_prot, erase_none_live, dat7_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NSECT-1:0]  sel_q, eff_q;

  assign prog_hit_prot   = sect_prot[prog_addr[ADDR_W-1 -: SECT_BITS]];
  assign erase_none_live = ~|(erase_sel & ~sect_prot);

  poll_fsm #(.CNT_W(CNT_W), .PROG_GUARD(PROG_GUARD), .ERASE_GUARD(ERASE_GUARD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
    .core_busy(core_busy), .prog_hit_prot(prog_hit_prot),
    .erase_none_live(erase_none_live), .st(st), .kind(kind), .take(take)
  );

  poll_ctx #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_ctx (
    .clk(clk), .rst_n(rst_n), .take(take), .prog_addr(prog_addr),
    .prog_msb(prog_msb), .erase_sel(erase_sel), .sect_prot(sect_prot),
    .addr_q(addr_q), .dat7_q(dat7_q), .sel_q(sel_q), .eff_q(eff_q)
  );

  poll_out #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .NSECT(NSECT)) u_out (
    .st(st), .kind(kind), .erase_susp(erase_susp), .rd_addr(rd_addr),
    .array_data(array_data), .addr_q(addr_q), .dat7_q(dat7_q),
    .sel_q(sel_q), .eff_q(eff_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/poll_status_gen_chk.sv
module poll_status_gen_chk
  import poll_status_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 12,
  parameter int SECT_BITS   = 3,
  parameter int PROG_GUARD  = 4,
  parameter int ERASE_GUARD = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      op_start,
  input logic                      erase_susp,
  input logic [ADDR_W-1:0]         rd_addr,
  input logic [DATA_W-1:0]         rd_data,
  input logic [DATA_W-1:0]         array_data,
  input pstate_e                   st,
  input opkind_e                   kind,
  input logic [ADDR_W-1:0]         addr_q,
  input logic                      dat7_q,
  input logic [(1<<SECT_BITS)-1:0] eff_q
);
  logic [15:0] gcnt, glim;

  assign glim = (kind == OPK_ERASE) ? 16'(ERASE_GUARD) : 16'(PROG_GUARD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gcnt <= '0;
    else if (st == PS_GUARD)  gcnt <= gcnt + 16'd1;
    else                      gcnt <= '0;
  end

  // R1
  idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_IDLE) |-> (rd_data == array_data));

  // R2
  prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_PROG && rd_addr == addr_q) |-> (rd_data[DATA_W-1] != dat7_q));

  // R3
  tail_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_TAIL) |=> (st == PS_IDLE));

  // R4
  erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_ERASE && !erase_susp && eff_q[rd_addr[ADDR_W-1 -: SECT_BITS]])
      |-> (rd_data[DATA_W-1] == 1'b0));

  // R6
  guard_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_GUARD) |-> (gcnt < glim));

  // R7
  guard_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_GUARD && gcnt == glim - 16'd1) |=> (st == PS_IDLE));

  // R8
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PS_IDLE) |=> ($stable(addr_q) && $stable(eff_q) && $stable(dat7_q)));

  // R9
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_IDLE && op_start) |=> (st != PS_IDLE));
endmodule

bind poll_status_gen poll_status_gen_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS),
  .PROG_GUARD(PROG_GUARD), .ERASE_GUARD(ERASE_GUARD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .erase_susp(erase_susp),
  .rd_addr(rd_addr), .rd_data(rd_data), .array_data(array_data),
  .st(st), .kind(kind), .addr_q(addr_q), .dat7_q(dat7_q), .eff_q(eff_q)
);

// File: tb/poll_status_gen_tb.sv
`timescale 1ns/1ps
module poll_status_gen_tb;
  localparam int DW = 8, AW = 12, SB = 3, NS = 8, PG = 4, EG = 8;

  logic clk, rst_n, op_start, op_is_erase, core_busy, erase_susp, prog_msb;
  logic [AW-1:0] rd_addr, prog_addr;
  logic [DW-1:0] array_data, rd_data;
  logic [NS-1:0] erase_sel, sect_prot;

  int n_chk, n_fail;
  int m_st, m_cnt;
  bit m_er, m_d7, m_new, m_ign, done;
  logic [AW-1:0] m_addr;
  logic [NS-1:0] m_sel, m_eff;

  poll_status_gen #(.DATA_W(DW), .ADDR_W(AW), .SECT_BITS(SB),
                    .PROG_GUARD(PG), .ERASE_GUARD(EG)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
    .core_busy(core_busy), .erase_susp(erase_susp), .rd_addr(rd_addr),
    .array_data(array_data), .prog_addr(prog_addr), .prog_msb(prog_msb),
    .erase_sel(erase_sel), .sect_prot(sect_prot), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit exp_show();
    logic [SB-1:0] s = rd_addr[AW-1 -: SB];
    case (m_st)
      1: return rd_addr == m_addr;
      2: return m_eff[s];
      3: return m_er ? m_eff[s] : (rd_addr == m_addr);
      4: return m_er ? m_sel[s] : (rd_addr == m_addr);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_data();
    bit b;
    case (m_st)
      1: b = !m_d7;
      2: b = erase_susp;
      3: b = m_er ? 1'b1 : m_d7;
      4: b = m_er ? 1'b0 : !m_d7;
      default: b = 1'b0;
    endcase
    return exp_show() ? {b, 7'b0} : array_data;
  endfunction

  function automatic string exp_tag();
    string t;
    if (m_st == 0)       t = "R1";
    else if (!exp_show()) t = "R5";
    else if (m_st == 1)  t = "R2";
    else if (m_st == 2)  t = "R4";
    else if (m_st == 3)  t = "R3";
    else                 t = m_er ? "R7" : "R6";
    if (m_new) t = {t, "/R9"};
    if (m_ign) t = {t, "/R8"};
    return t;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    #1;
    check(exp_tag(), rd_data, exp_data());
    @(posedge clk);
    m_new = 1'b0;
    case (m_st)
      0: if (op_start) begin
        m_er = op_is_erase; m_addr = prog_addr; m_d7 = prog_msb;
        m_sel = erase_sel; m_eff = erase_sel & ~sect_prot;
        m_new = 1'b1; m_ign = 1'b0;
        if (op_is_erase) begin
          if (m_eff == '0) begin m_st = 4; m_cnt = EG; end else m_st = 2;
        end else if (sect_prot[prog_addr[AW-1 -: SB]]) begin
          m_st = 4; m_cnt = PG;
        end else m_st = 1;
      end
      1, 2: begin if (op_start) m_ign = 1'b1; if (!core_busy) m_st = 3; end
      3: begin if (op_start) m_ign = 1'b1; m_st = 0; end
      default: begin
        if (op_start) m_ign = 1'b1;
        m_cnt--;
        if (m_cnt == 0) m_st = 0;
      end
    endcase
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    n_chk = 0; n_fail = 0; done = 1'b0;
    m_st = 0; m_cnt = 0; m_er = 0; m_d7 = 0; m_new = 0; m_ign = 0;
    m_addr = '0; m_sel = '0; m_eff = '0;
    rst_n = 1'b0; op_start = 0; op_is_erase = 0; core_busy = 0; erase_susp = 0;
    prog_msb = 0; rd_addr = '0; prog_addr = '0; array_data = 8'h5A;
    erase_sel = '0; sect_prot = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state passes array data
    step();

    // R2, R3, R8, R9: unprotected program, late input changes
    prog_addr = 12'h123; prog_msb = 1'b1; rd_addr = 12'h123;
    op_start = 1; core_busy = 1; step();
    op_start = 0; prog_msb = 1'b0; prog_addr = 12'h777; step();
    op_start = 1; step();
    op_start = 0; rd_addr = 12'h124; array_data = 8'hC3; step();
    rd_addr = 12'h123; core_busy = 0; step();
    step(); step();

    // R4, R5: partly protected erase with suspension
    erase_sel = 8'b0000_0110; sect_prot = 8'b0000_0100;
    op_is_erase = 1; op_start = 1; core_busy = 1; rd_addr = 12'h200; step();
    op_start = 0; step();
    erase_susp = 1; step();
    erase_susp = 0; rd_addr = 12'h400; step();
    rd_addr = 12'hE00; step();
    rd_addr = 12'h2FF; core_busy = 0; step();
    step();

    // R7: all selected sectors protected
    erase_sel = 8'h30; sect_prot = 8'h30; rd_addr = 12'hA00;
    op_start = 1; core_busy = 1; step();
    op_start = 0;
    for (int i = 0; i < EG + 2; i++) step();

    // R7, R5: empty selection
    erase_sel = 8'h00; sect_prot = 8'h00; op_start = 1; step();
    op_start = 0;
    for (int i = 0; i < EG + 1; i++) step();

    // R6: protected program, busy held high
    op_is_erase = 0; sect_prot = 8'hFF; prog_addr = 12'h345; prog_msb = 1'b0;
    rd_addr = 12'h345; op_start = 1; core_busy = 1; step();
    op_start = 0;
    for (int i = 0; i < PG + 2; i++) step();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      op_start    = ($urandom % 6) == 0;
      op_is_erase = $urandom % 2;
      core_busy   = ($urandom % 8) != 0;
      erase_susp  = ($urandom % 4) == 0;
      prog_addr   = AW'($urandom);
      prog_msb    = $urandom % 2;
      erase_sel   = NS'($urandom);
      case ($urandom % 4)
        0: sect_prot = '0;
        1: sect_prot = '1;
        default: sect_prot = NS'($urandom);
      endcase
      rd_addr    = ($urandom % 2) ? m_addr : AW'($urandom);
      array_data = DW'($urandom);
      step();
    end

    done = 1'b1;
    finish_run();
  end
endmodule